// File: doc/BRIEF.md
# Compressed-Row Automaton Stepper

This block advances a multi-pattern string-matching automaton by one input byte at a time. The transition table is held in compressed form. Each state owns a short list of (symbol, target) pairs covering only the transitions that do not fall back to the start state. A per-state offset array marks where each list begins, and the next state's offset marks where it ends.

Each byte arrives on a valid/ready handshake. The stepper then examines the current state's pairs one per cycle. On the first pair whose symbol equals the byte it moves to that pair's target. If it reaches the end of the list without a hit, it returns to state 0. When the new state is accepting, it raises a one-cycle match pulse that carries the state number.

The tables are register arrays that are written through a simple configuration port. The configuration port is a write port only. Producing table contents is left to software.

Top module: `dfa_sr_stepper`

## Requirements
- R1: After reset the current state is 0, `step_done_o` and `match_o` are low, `in_ready_o` is high, and all table entries read as zero.
- R2: A byte is taken only in a cycle where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` stays low from the cycle after acceptance until the cycle that carries the result. Bytes presented while it is low are ignored.
- R3: If the current state's pair list holds a pair whose symbol equals the byte, the new state is that pair's target.
- R4: If no pair in the list matches the byte, the new state is 0. This includes the case of an empty list.
- R5: `match_o` is high, together with `step_done_o`, exactly when the new state is marked accepting. In that cycle `match_state_o` equals the new state.
- R6: The result is registered j+1 cycles after the acceptance edge for a hit at list position j (counted from 0). For a miss in a list of length L it is registered L+1 cycles after the acceptance edge.
- R7: The pairs of state s occupy pair indices offset[s] through offset[s+1]-1 and are examined in ascending index order. If two pairs share a symbol, the lower index wins.
- R8: The configuration write encoding is as follows. Select 0 writes offset entry `cfg_addr_i` (0..NUM_STATES) from the low bits of `cfg_data_i`. Select 1 writes pair `cfg_addr_i` with the symbol in the upper SYM_W bits and the target in the low state bits. Select 2 writes the accept flag of state `cfg_addr_i` from bit 0.
- R9: `step_done_o` pulses for exactly one cycle per accepted byte, and `state_o` changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 2 | Table select: 0 offset, 1 pair, 2 accept |
| cfg_addr_i | input | ADDR_W | Entry index within the selected table |
| cfg_data_i | input | SYM_W+STATE_W | Write data |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Stepper idle and able to take a byte |
| in_byte_i | input | SYM_W | Input symbol |
| state_o | output | STATE_W | Current automaton state |
| step_done_o | output | 1 | One-cycle pulse when a byte has been resolved |
| match_o | output | 1 | New state is accepting |
| match_state_o | output | STATE_W | State number reported with the match |

## Verification
The bench builds the stepper with 8 states, 16 pair slots and 8-bit symbols. At that size the pair memory can hold a hand-written automaton with lists of length 0, 1, 2 and 3. That range covers empty-list misses, hits at the first and third position, full-length misses, and a duplicated symbol that shows the lower index wins. The small sizes also let the bench rewrite a single pair at run time and confirm that the changed target takes effect. Latency is measured against the list position for every byte.

// File: rtl/dfa_sr_pkg.sv
package dfa_sr_pkg;

  typedef enum logic [1:0] {
    CFG_OFFSET = 2'd0,
    CFG_PAIR   = 2'd1,
    CFG_ACCEPT = 2'd2
  } cfg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_fsm_e;

endpackage

// File: rtl/dfa_sr_tables.sv
module dfa_sr_tables
  import dfa_sr_pkg::*;
#(
  parameter int NUM_STATES = 16,
  parameter int NUM_PAIRS  = 64,
  parameter int SYM_W      = 8,
  parameter int STATE_W    = 4,
  parameter int PIDX_W     = 7,
  parameter int PA_W       = 6,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [DATA_W-1:0]  cfg_data_i,
  input  logic [STATE_W-1:0] rd_state_i,
  output logic [PIDX_W-1:0]  rd_lo_o,
  output logic [PIDX_W-1:0]  rd_hi_o,
  input  logic [PA_W-1:0]    pair_addr_i,
  output logic [SYM_W-1:0]   pair_sym_o,
  output logic [STATE_W-1:0] pair_nxt_o,
  input  logic [STATE_W-1:0] acc_state_i,
  output logic               acc_o
);

  logic [PIDX_W-1:0]  offset_q   [NUM_STATES+1];
  logic [SYM_W-1:0]   pair_sym_q [NUM_PAIRS];
  logic [STATE_W-1:0] pair_nxt_q [NUM_PAIRS];
  logic               acc_q      [NUM_STATES];

  logic wr_off, wr_pair, wr_acc;
  assign wr_off  = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == CFG_OFFSET);
  assign wr_pair = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == CFG_PAIR);
  assign wr_acc  = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == CFG_ACCEPT);

  for (genvar g = 0; g <= NUM_STATES; g++) begin : g_off
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  offset_q[g] <= '0;
      else if (wr_off && cfg_addr_i == ADDR_W'(g))  offset_q[g] <= cfg_data_i[PIDX_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pair_sym_q[g] <= '0;
        pair_nxt_q[g] <= '0;
      end else if (wr_pair && cfg_addr_i == ADDR_W'(g)) begin
        pair_sym_q[g] <= cfg_data_i[DATA_W-1 -: SYM_W];
        pair_nxt_q[g] <= cfg_data_i[STATE_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  acc_q[g] <= 1'b0;
      else if (wr_acc && cfg_addr_i == ADDR_W'(g))  acc_q[g] <= cfg_data_i[0];
    end
  end

  logic [STATE_W:0] s_ext;
  assign s_ext = {1'b0, rd_state_i};

  assign rd_lo_o    = offset_q[s_ext];
  assign rd_hi_o    = offset_q[s_ext + 1'b1];
  assign pair_sym_o = pair_sym_q[pair_addr_i];
  assign pair_nxt_o = pair_nxt_q[pair_addr_i];
  assign acc_o      = acc_q[acc_state_i];

endmodule

// File: rtl/dfa_sr_scan.sv
module dfa_sr_scan
  import dfa_sr_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int STATE_W = 4,
  parameter int PIDX_W  = 7,
  parameter int PA_W    = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [SYM_W-1:0]   in_byte_i,
  output logic [STATE_W-1:0] cur_state_o,
  input  logic [PIDX_W-1:0]  lo_i,
  input  logic [PIDX_W-1:0]  hi_i,
  output logic [PA_W-1:0]    pair_addr_o,
  input  logic [SYM_W-1:0]   pair_sym_i,
  input  logic [STATE_W-1:0] pair_nxt_i,
  output logic [STATE_W-1:0] nxt_state_o,
  input  logic               nxt_acc_i,
  output logic               done_o,
  output logic               match_o,
  output logic [STATE_W-1:0] match_state_o
);

  scan_fsm_e          fsm_q;
  logic [STATE_W-1:0] state_q, mstate_q;
  logic [SYM_W-1:0]   byte_q;
  logic [PIDX_W-1:0]  idx_q, end_q;
  logic               done_q, match_q;

  logic at_end, hit, resolve;
  assign at_end  = (idx_q == end_q);
  assign hit     = !at_end && (pair_sym_i == byte_q);
  assign resolve = (fsm_q == ST_SCAN) && (hit || at_end);

  // miss falls back to the start state
  assign nxt_state_o = hit ? pair_nxt_i : '0;
  assign pair_addr_o = idx_q[PA_W-1:0];
  assign in_ready_o  = (fsm_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q    <= ST_IDLE;
      state_q  <= '0;
      mstate_q <= '0;
      byte_q   <= '0;
      idx_q    <= '0;
      end_q    <= '0;
      done_q   <= 1'b0;
      match_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
      unique case (fsm_q)
        ST_IDLE: if (in_valid_i) begin
          byte_q <= in_byte_i;
          idx_q  <= lo_i;
          end_q  <= hi_i;
          fsm_q  <= ST_SCAN;
        end
        ST_SCAN: if (resolve) begin
          state_q  <= nxt_state_o;
          mstate_q <= nxt_state_o;
          done_q   <= 1'b1;
          match_q  <= nxt_acc_i;
          fsm_q    <= ST_IDLE;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
        default: fsm_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_state_o   = state_q;
  assign done_o        = done_q;
  assign match_o       = match_q;
  assign match_state_o = mstate_q;

endmodule

// File: rtl/dfa_sr_stepper.sv
module dfa_sr_stepper
  import dfa_sr_pkg::*;
#(
  parameter int NUM_STATES = 16,
  parameter int NUM_PAIRS  = 64,
  parameter int SYM_W      = 8,
  localparam int STATE_W   = $clog2(NUM_STATES),
  localparam int PA_W      = $clog2(NUM_PAIRS),
  localparam int PIDX_W    = $clog2(NUM_PAIRS + 1),
  localparam int ADDR_W    = (PA_W > STATE_W + 1) ? PA_W : STATE_W + 1,
  localparam int DATA_W    = SYM_W + STATE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [DATA_W-1:0]  cfg_data_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [SYM_W-1:0]   in_byte_i,
  output logic [STATE_W-1:0] state_o,
  output logic               step_done_o,
  output logic               match_o,
  output logic [STATE_W-1:0] match_state_o
);

  logic [PIDX_W-1:0]  lo, hi;
  logic [PA_W-1:0]    pair_addr;
  logic [SYM_W-1:0]   pair_sym;
  logic [STATE_W-1:0] pair_nxt, nxt_state, cur_state;
  logic               nxt_acc;

  dfa_sr_tables #(
    .NUM_STATES(NUM_STATES), .NUM_PAIRS(NUM_PAIRS), .SYM_W(SYM_W),
    .STATE_W(STATE_W), .PIDX_W(PIDX_W), .PA_W(PA_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_tables (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_data_i  (cfg_data_i),
    .rd_state_i  (cur_state),
    .rd_lo_o     (lo),
    .rd_hi_o     (hi),
    .pair_addr_i (pair_addr),
    .pair_sym_o  (pair_sym),
    .pair_nxt_o  (pair_nxt),
    .acc_state_i (nxt_state),
    .acc_o       (nxt_acc)
  );

  dfa_sr_scan #(
    .SYM_W(SYM_W), .STATE_W(STATE_W), .PIDX_W(PIDX_W), .PA_W(PA_W)
  ) u_scan (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_valid_i    (in_valid_i),
    .in_ready_o    (in_ready_o),
    .in_byte_i     (in_byte_i),
    .cur_state_o   (cur_state),
    .lo_i          (lo),
    .hi_i          (hi),
    .pair_addr_o   (pair_addr),
    .pair_sym_i    (pair_sym),
    .pair_nxt_i    (pair_nxt),
    .nxt_state_o   (nxt_state),
    .nxt_acc_i     (nxt_acc),
    .done_o        (step_done_o),
    .match_o       (match_o),
    .match_state_o (match_state_o)
  );

  assign state_o = cur_state;

endmodule

// File: rtl/dfa_sr_stepper_chk.sv
module dfa_sr_stepper_chk #(
  parameter int STATE_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic [STATE_W-1:0] state_o,
  input logic               step_done_o,
  input logic               match_o,
  input logic [STATE_W-1:0] match_state_o
);

  // R2
  accept_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  // R2
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |-> in_ready_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |=> !step_done_o);

  // R9
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_done_o |-> $stable(state_o));

  // R5
  match_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> step_done_o);

  // R5
  match_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (match_state_o == state_o));

endmodule

bind dfa_sr_stepper dfa_sr_stepper_chk #(.STATE_W(STATE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .state_o       (state_o),
  .step_done_o   (step_done_o),
  .match_o       (match_o),
  .match_state_o (match_state_o)
);

// File: tb/dfa_sr_stepper_test.sv
module dfa_sr_stepper_test;

  localparam int NS      = 8;
  localparam int NP      = 16;
  localparam int SW      = 8;
  localparam int STW     = $clog2(NS);
  localparam int PAW     = $clog2(NP);
  localparam int AW      = (PAW > STW + 1) ? PAW : STW + 1;
  localparam int DW      = SW + STW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_byte = '0;
  logic          in_ready_o, step_done_o, match_o;
  logic [STW-1:0] state_o, match_state_o;

  always #10 clk = ~clk;

  dfa_sr_stepper #(.NUM_STATES(NS), .NUM_PAIRS(NP), .SYM_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_byte_i(in_byte),
    .state_o(state_o), .step_done_o(step_done_o),
    .match_o(match_o), .match_state_o(match_state_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench mirror of the programmed tables
  int boff [NS+1];
  int bsym [NP];
  int bnxt [NP];
  bit bacc [NS];
  int exp_state = 0;

  typedef struct {
    int    st;
    bit    m;
    int    lat;
    int    acc;
    string tag;
  } exp_t;
  exp_t sb [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_addr = addr[AW-1:0]; cfg_data = data[DW-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 0) boff[addr] = data;
    if (sel == 1) begin bsym[addr] = (data >> STW) & 8'hff; bnxt[addr] = data & (NS-1); end
    if (sel == 2) bacc[addr] = data[0];
  endtask

  task automatic pair(input int idx, input int sym, input int nxt);
    cfg(1, idx, (sym << STW) | nxt);
  endtask

  function automatic void model(input int s, input int b, output int nxt, output int lat);
    int lo = boff[s];
    int hi = boff[s+1];
    nxt = 0;
    lat = hi - lo + 1;
    for (int i = lo; i < hi; i++) begin
      if (bsym[i] == b) begin
        nxt = bnxt[i];
        lat = i - lo + 1;
        break;
      end
    end
  endfunction

  // driver: push expectation, present byte; noisy holds a junk byte during the scan
  task automatic send(input int b, input string tag, input bit noisy = 1'b0);
    int nxt, lat;
    exp_t e;
    @(negedge clk);
    while (!in_ready_o) @(negedge clk);
    model(exp_state, b, nxt, lat);
    e.st = nxt; e.m = bacc[nxt]; e.lat = lat; e.acc = cyc + 1; e.tag = tag;
    sb.push_back(e);
    exp_state = nxt;
    in_valid = 1'b1; in_byte = b[SW-1:0];
    @(negedge clk);
    check(in_ready_o == 1'b0, "R2 ready low during scan", int'(in_ready_o), 0);
    if (noisy) begin
      in_byte = 8'h7a;
      while (!in_ready_o) @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // monitor: pop and compare on each resolved byte
  always @(negedge clk) begin
    if (rst_n && step_done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected step result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(state_o) == e.st, {e.tag, " next state"}, int'(state_o), e.st);
        check(match_o == e.m, "R5 match flag", int'(match_o), int'(e.m));
        if (e.m) check(int'(match_state_o) == e.st, "R5 match state", int'(match_state_o), e.st);
        check(cyc - e.acc == e.lat, "R6 latency", cyc - e.acc, e.lat);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i <= NS; i++) boff[i] = 0;
    for (int i = 0; i < NP; i++) begin bsym[i] = 0; bnxt[i] = 0; end
    for (int i = 0; i < NS; i++) bacc[i] = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(state_o == '0, "R1 reset state", int'(state_o), 0);
    check(step_done_o == 1'b0 && match_o == 1'b0, "R1 reset flags", int'(step_done_o | match_o), 0);
    check(in_ready_o == 1'b1, "R1 reset ready", int'(in_ready_o), 1);

    // empty tables: any byte returns to 0 in one cycle (R1, R4)
    send(8'h61, "R1 empty table");

    // program automaton (R8)
    cfg(0, 0, 0);  cfg(0, 1, 2);  cfg(0, 2, 5);  cfg(0, 3, 6);
    cfg(0, 4, 7);  cfg(0, 5, 8);  cfg(0, 6, 9);  cfg(0, 7, 11); cfg(0, 8, 11);
    pair(0, 8'h61, 1);  pair(1, 8'h62, 4);
    pair(2, 8'h62, 2);  pair(3, 8'h63, 3);  pair(4, 8'h61, 1);
    pair(5, 8'h63, 5);
    pair(6, 8'h61, 1);
    pair(7, 8'h63, 6);
    pair(8, 8'h64, 7);
    pair(9, 8'h64, 7);  pair(10, 8'h64, 2);
    cfg(2, 3, 1); cfg(2, 5, 1); cfg(2, 7, 1);

    send(8'h61, "R3 hit pos0");
    send(8'h62, "R3 hit pos0 s1");
    send(8'h63, "R3 single pair");
    send(8'h64, "R5 accept chain");
    send(8'h78, "R4 empty list miss");
    send(8'h61, "R3 from start");
    send(8'h63, "R6 hit pos1");
    send(8'h71, "R4 miss len1");
    send(8'h62, "R6 hit pos1 s0");
    send(8'h63, "R3 s4");
    send(8'h64, "R7 duplicate lower wins");
    send(8'h61, "R4 accept empty miss");
    send(8'h7a, "R4 full miss len2");
    send(8'h61, "R3 enter s1");
    send(8'h61, "R2 noisy hit pos2", 1'b1);
    send(8'h7a, "R4 full miss len3");

    // rewrite one pair target (R8)
    pair(6, 8'h61, 5);
    send(8'h61, "R3 to s1");
    send(8'h63, "R3 to s3");
    send(8'h61, "R8 rewritten target");

    @(negedge clk);
    while (!in_ready_o || sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R9 all results seen", sb.size(), 0);
    check(int'(state_o) == exp_state, "R9 final state", int'(state_o), exp_state);
    finish_run();
  end

endmodule